// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Multiplexer

This block gathers 96 single-cycle event pulses from peripherals and folds them onto twelve processor interrupt lines, eight sources per line. Each source keeps a latched pending flag and a software-written enable bit. A group whose line has fired holds a per-group "in service" bit. While that bit is set, the group cannot fire again, even if more of its sources become pending. Software writes a 1 to release the bit once it is ready for more work from that group.

When the processor takes a line, it presents the group number on the fetch port. One cycle later the block returns the 32-bit handler vector of the lowest-numbered source in that group that is both pending and enabled. In the same cycle it clears that source's flag. The vector for each source comes from an internal table that software fills through the same write interface as the control, release and enable registers. A master enable gates the whole block: while it is off, no line fires and no fetch is served.

Top module: `irq_expander`

## Requirements
- R1: After reset, every pending flag, enable bit, in-service bit, the master enable and every vector table entry are 0, and `cpu_irq` and `fetch_hit` are 0.
- R2: A 1 on `src_pulse[n]` latches the pending flag of source n, where source n belongs to group n/8 at position n%8.
- R3: When the master enable is set, the in-service bit of group g is clear and some source in g is both pending and enabled, `cpu_irq[g]` pulses high for exactly one cycle and the group's in-service bit becomes set.
- R4: A set in-service bit blocks any further pulse on `cpu_irq[g]`. It stays set until a write to address 0x01 carries a 1 in data bit g. A 0 in bit g leaves it unchanged.
- R5: The master enable is data bit 0 of address 0x00 and resets to 0. While it is 0, no `cpu_irq` pulse occurs, fetches return `fetch_hit`=0, and pending flags are kept.
- R6: A fetch of group g (`fetch_req`=1) is answered on the next cycle. `fetch_hit`=1, `fetch_src` is the lowest source index in g that is pending and enabled, and `fetch_vec` is that source's table entry. If no such source exists, `fetch_hit`, `fetch_src` and `fetch_vec` are all 0.
- R7: A served fetch clears only the pending flag of the returned source. Other pending flags in the group remain.
- R8: A `src_pulse` for a source in the same cycle that a fetch clears that source's flag leaves the flag set.
- R9: The enable byte of group g is written at address 0x10+g, data bits 7:0. A pending but disabled source neither fires the line nor is selected, but it keeps its flag and acts once enabled.
- R10: A write to address 0x80+n (n < 96) stores the 32-bit data as the vector of source n.
- R11: A fetch naming a group number of 12 or above returns `fetch_hit`=0 and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 96 | One-cycle event pulses from peripherals, one per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register word address |
| reg_wr_data | input | 32 | Register write data |
| fetch_req | input | 1 | Vector fetch request |
| fetch_grp | input | 4 | Group being fetched |
| cpu_irq | output | 12 | One-cycle request pulse per group |
| fetch_hit | output | 1 | Fetch response carries a valid vector |
| fetch_src | output | 7 | Source index selected by the fetch |
| fetch_vec | output | 32 | Vector of the selected source |

## Verification
On every cycle, the assertions check four things. Each line pulse lasts one cycle and starts only from a clear in-service bit. The in-service bit holds until a release write. Nothing fires or is served while the master enable is off. Every served vector lies in the group that was requested. Only the bench's scenarios can show the priority order within a group, which flag a fetch clears and which it keeps, and that the returned vector matches the loaded table. They alone also show a pulse colliding with its own clear, and a disabled source that stays latched until it is enabled.

// File: rtl/irqx_pkg.sv
`timescale 1ns/1ps
package irqx_pkg;
    localparam int DATA_W    = 32;
    localparam int CTRL_ADDR = 0;   // master enable in bit 0
    localparam int REL_ADDR  = 1;   // write-one-to-release in-service bits
    localparam int EN_BASE   = 16;  // group enable bytes start here
endpackage

// File: rtl/irqx_regif.sv
`timescale 1ns/1ps
module irqx_regif
    import irqx_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_GRP = 12,
    parameter int GRP_SZ  = 8,
    parameter int NSRC    = NUM_GRP * GRP_SZ,
    parameter int SRC_W   = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                glob_en,
    output logic [NUM_GRP-1:0]  rel_bits,
    output logic [NUM_GRP-1:0]  en_wr,
    output logic [GRP_SZ-1:0]   en_data,
    output logic                vec_wr,
    output logic [SRC_W-1:0]    vec_idx,
    output logic [DATA_W-1:0]   vec_data
);
    localparam logic [ADDR_W-1:0] VEC_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

    typedef struct packed {
        logic glob_en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [ADDR_W-1:0] vec_off;
    logic              data_unused;

    assign data_unused = ^wr_data[DATA_W-1:GRP_SZ];

    always_comb begin
        ctl_d    = ctl_q;
        rel_bits = '0;
        en_wr    = '0;
        en_data  = wr_data[GRP_SZ-1:0];
        vec_data = wr_data;
        vec_off  = wr_addr - VEC_BASE;
        vec_idx  = vec_off[SRC_W-1:0];
        vec_wr   = wr_en && wr_addr[ADDR_W-1] && (vec_off < ADDR_W'(NSRC));
        if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
            ctl_d.glob_en = wr_data[0];
        end
        if (wr_en && wr_addr == ADDR_W'(REL_ADDR)) begin
            rel_bits = wr_data[NUM_GRP-1:0];
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (wr_en && wr_addr == ADDR_W'(EN_BASE + g)) begin
                en_wr[g] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign glob_en = ctl_q.glob_en;
endmodule

// File: rtl/irqx_group.sv
`timescale 1ns/1ps
module irqx_group #(
    parameter int GRP_SZ = 8,
    parameter int IDX_W  = (GRP_SZ > 1) ? $clog2(GRP_SZ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic [GRP_SZ-1:0] src_pulse,
    input  logic              en_wr,
    input  logic [GRP_SZ-1:0] en_data,
    input  logic              rel,
    input  logic              fetch_sel,
    output logic              irq,
    output logic              in_svc,
    output logic              pend_any,
    output logic [IDX_W-1:0]  pick_idx
);
    typedef struct packed {
        logic [GRP_SZ-1:0] flag;
        logic [GRP_SZ-1:0] en;
        logic              svc;
        logic              irq;
    } grp_t;

    grp_t st_d, st_q;
    logic [GRP_SZ-1:0] live;
    logic [GRP_SZ-1:0] lowest;
    logic [GRP_SZ-1:0] clr_vec;
    logic              raise;

    always_comb begin
        st_d     = st_q;
        live     = st_q.flag & st_q.en;
        pend_any = |live;
        lowest   = live & (~live + GRP_SZ'(1));
        pick_idx = '0;
        for (int i = GRP_SZ - 1; i >= 0; i--) begin
            if (live[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
        clr_vec   = fetch_sel ? lowest : '0;
        // a new event wins over the clear of its own flag
        st_d.flag = (st_q.flag & ~clr_vec) | src_pulse;
        if (en_wr) begin
            st_d.en = en_data;
        end
        raise    = glob_en && !st_q.svc && pend_any;
        st_d.svc = (st_q.svc && !rel) || raise;
        st_d.irq = raise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq    = st_q.irq;
    assign in_svc = st_q.svc;
endmodule

// File: rtl/irqx_vectab.sv
`timescale 1ns/1ps
module irqx_vectab
    import irqx_pkg::*;
#(
    parameter int NSRC  = 96,
    parameter int SRC_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SRC_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SRC_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_d [NSRC];
    logic [DATA_W-1:0] mem_q [NSRC];

    always_comb begin
        for (int n = 0; n < NSRC; n++) begin
            mem_d[n] = mem_q[n];
            if (wr && wr_idx == SRC_W'(n)) begin
                mem_d[n] = wr_data;
            end
        end
        rd_data = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (rd_idx == SRC_W'(n)) begin
                rd_data = mem_q[n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NSRC; n++) begin
                mem_q[n] <= '0;
            end
        end else begin
            for (int n = 0; n < NSRC; n++) begin
                mem_q[n] <= mem_d[n];
            end
        end
    end
endmodule

// File: rtl/irq_expander.sv
`timescale 1ns/1ps
module irq_expander
    import irqx_pkg::*;
#(
    parameter int NUM_GRP = 12,
    parameter int GRP_SZ  = 8,
    parameter int ADDR_W  = 8,
    localparam int NSRC   = NUM_GRP * GRP_SZ,
    localparam int SRC_W  = $clog2(NSRC),
    localparam int GRP_W  = $clog2(NUM_GRP),
    localparam int IDX_W  = (GRP_SZ > 1) ? $clog2(GRP_SZ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_pulse,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_wr_addr,
    input  logic [DATA_W-1:0]   reg_wr_data,
    input  logic                fetch_req,
    input  logic [GRP_W-1:0]    fetch_grp,
    output logic [NUM_GRP-1:0]  cpu_irq,
    output logic                fetch_hit,
    output logic [SRC_W-1:0]    fetch_src,
    output logic [DATA_W-1:0]   fetch_vec
);
    typedef struct packed {
        logic              hit;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] vec;
    } resp_t;

    logic                glob_en;
    logic [NUM_GRP-1:0]  ack_clr;
    logic [NUM_GRP-1:0]  en_wr;
    logic [GRP_SZ-1:0]   en_data;
    logic                vec_wr;
    logic [SRC_W-1:0]    vec_idx;
    logic [DATA_W-1:0]   vec_data;
    logic [NUM_GRP-1:0]  ack_all;
    logic [NUM_GRP-1:0]  pend_all;
    logic [IDX_W-1:0]    pick_all [NUM_GRP];
    logic [NUM_GRP-1:0]  fetch_sel;
    logic                sel_pend;
    logic [IDX_W-1:0]    sel_pick;
    logic [SRC_W-1:0]    src_idx;
    logic [DATA_W-1:0]   tab_rd;
    resp_t               rsp_d, rsp_q;

    irqx_regif #(
        .ADDR_W (ADDR_W),
        .NUM_GRP(NUM_GRP),
        .GRP_SZ (GRP_SZ),
        .NSRC   (NSRC),
        .SRC_W  (SRC_W)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .glob_en (glob_en),
        .rel_bits(ack_clr),
        .en_wr   (en_wr),
        .en_data (en_data),
        .vec_wr  (vec_wr),
        .vec_idx (vec_idx),
        .vec_data(vec_data)
    );

    irqx_vectab #(
        .NSRC (NSRC),
        .SRC_W(SRC_W)
    ) u_vectab (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (vec_wr),
        .wr_idx (vec_idx),
        .wr_data(vec_data),
        .rd_idx (src_idx),
        .rd_data(tab_rd)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign fetch_sel[g] = fetch_req && glob_en && (fetch_grp == GRP_W'(g));

        irqx_group #(
            .GRP_SZ(GRP_SZ),
            .IDX_W (IDX_W)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .glob_en  (glob_en),
            .src_pulse(src_pulse[g*GRP_SZ +: GRP_SZ]),
            .en_wr    (en_wr[g]),
            .en_data  (en_data),
            .rel      (ack_clr[g]),
            .fetch_sel(fetch_sel[g]),
            .irq      (cpu_irq[g]),
            .in_svc   (ack_all[g]),
            .pend_any (pend_all[g]),
            .pick_idx (pick_all[g])
        );
    end

    always_comb begin
        sel_pend = 1'b0;
        sel_pick = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (fetch_grp == GRP_W'(g)) begin
                sel_pend = pend_all[g];
                sel_pick = pick_all[g];
            end
        end
        src_idx   = SRC_W'(int'(fetch_grp) * GRP_SZ + int'(sel_pick));
        rsp_d     = '0;
        rsp_d.hit = fetch_req && glob_en && sel_pend;
        if (rsp_d.hit) begin
            rsp_d.src = src_idx;
            rsp_d.vec = tab_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign fetch_hit = rsp_q.hit;
    assign fetch_src = rsp_q.src;
    assign fetch_vec = rsp_q.vec;
endmodule

// File: rtl/irq_expander_chk.sv
`timescale 1ns/1ps
module irq_expander_chk #(
    parameter int NUM_GRP = 12,
    parameter int GRP_SZ  = 8,
    parameter int GRP_W   = 4,
    parameter int SRC_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glob_en,
    input logic [NUM_GRP-1:0] cpu_irq,
    input logic [NUM_GRP-1:0] ack,
    input logic [NUM_GRP-1:0] ack_clr,
    input logic               fetch_req,
    input logic [GRP_W-1:0]   fetch_grp,
    input logic               fetch_hit,
    input logic [SRC_W-1:0]   fetch_src
);
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (cpu_irq == '0) && !fetch_hit);

    a_r6_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> $past(fetch_req) && $past(glob_en));

    a_r11_grp_range: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> int'($past(fetch_grp)) < NUM_GRP);

    a_r6_src_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> (int'(fetch_src) / GRP_SZ) == int'($past(fetch_grp)));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        a_r3_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[g] |=> !cpu_irq[g]);

        a_r3_irq_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[g] |-> ack[g] && !$past(ack[g]));

        a_r4_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ack[g] && !ack_clr[g] |=> ack[g]);
    end
endmodule

bind irq_expander irq_expander_chk #(
    .NUM_GRP(NUM_GRP),
    .GRP_SZ (GRP_SZ),
    .GRP_W  (GRP_W),
    .SRC_W  (SRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glob_en  (glob_en),
    .cpu_irq  (cpu_irq),
    .ack      (ack_all),
    .ack_clr  (ack_clr),
    .fetch_req(fetch_req),
    .fetch_grp(fetch_grp),
    .fetch_hit(fetch_hit),
    .fetch_src(fetch_src)
);

// File: tb/irq_expander_test.sv
`timescale 1ns/1ps
module irq_expander_test;
    localparam int NG = 12;
    localparam int GS = 8;
    localparam int NS = NG * GS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_pulse = '0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wr_addr = '0;
    logic [31:0]   reg_wr_data = '0;
    logic          fetch_req = 1'b0;
    logic [3:0]    fetch_grp = '0;
    logic [NG-1:0] cpu_irq;
    logic          fetch_hit;
    logic [6:0]    fetch_src;
    logic [31:0]   fetch_vec;

    int checks = 0;
    int fails  = 0;
    int irq_cnt [NG] = '{default: 0};

    // rows: {group, enable byte, pulse byte, expect hit, expect source}
    localparam logic [31:0] ROWS [8] = '{
        {8'd0,  8'hFF, 8'h01, 1'b1, 7'd0},
        {8'd1,  8'hFF, 8'h80, 1'b1, 7'd15},
        {8'd2,  8'hF0, 8'h0F, 1'b0, 7'd0},
        {8'd3,  8'h0C, 8'hFF, 1'b1, 7'd26},
        {8'd11, 8'hFF, 8'hA0, 1'b1, 7'd93},
        {8'd5,  8'h81, 8'h81, 1'b1, 7'd40},
        {8'd7,  8'h00, 8'hFF, 1'b0, 7'd0},
        {8'd6,  8'hFE, 8'h03, 1'b1, 7'd49}
    };

    irq_expander uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_pulse  (src_pulse),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data),
        .fetch_req  (fetch_req),
        .fetch_grp  (fetch_grp),
        .cpu_irq    (cpu_irq),
        .fetch_hit  (fetch_hit),
        .fetch_src  (fetch_src),
        .fetch_vec  (fetch_vec)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        for (int g = 0; g < NG; g++) begin
            if (rst_n && cpu_irq[g]) irq_cnt[g] = irq_cnt[g] + 1;
        end
    end

    function automatic logic [31:0] vexp(int n);
        return {8'hC3, 8'(n), 16'(n * 37)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int addr, logic [31:0] data);
        reg_wr_en   = 1'b1;
        reg_wr_addr = 8'(addr);
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic pulse(logic [NS-1:0] v);
        src_pulse = v;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic fetch(int g);
        fetch_req = 1'b1;
        fetch_grp = 4'(g);
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic expect_fetch(string req, int g, logic hit, int src);
        fetch(g);
        chk(req, 32'(fetch_hit), 32'(hit));
        chk(req, 32'(fetch_src), hit ? 32'(src) : 32'd0);
        chk(req, fetch_vec, hit ? vexp(src) : 32'd0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int c0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: quiet after reset
        chk("R1 irq", 32'(cpu_irq), 0);
        chk("R1 hit", 32'(fetch_hit), 0);

        // R5: pending while master enable off
        wr(16, 32'hFF);
        c0 = irq_cnt[0];
        pulse(NS'(1) << 3);
        idle(3);
        chk("R5 no irq while off", 32'(irq_cnt[0] - c0), 0);
        fetch(0);
        chk("R5 no fetch while off", 32'(fetch_hit), 0);
        wr(0, 32'h1);
        idle(3);
        chk("R3 irq once after enable", 32'(irq_cnt[0] - c0), 1);
        fetch(0);
        chk("R2 latched src", 32'(fetch_src), 3);
        chk("R1 table reset", fetch_vec, 0);
        chk("R6 hit", 32'(fetch_hit), 1);
        expect_fetch("R7 flag cleared", 0, 1'b0, 0);

        // R10: load vector table
        for (int n = 0; n < NS; n++) wr(128 + n, vexp(n));

        // R4: in-service bit blocks until released with a 1
        c0 = irq_cnt[0];
        pulse(NS'(1) << 5);
        idle(3);
        chk("R4 blocked", 32'(irq_cnt[0] - c0), 0);
        wr(1, 32'h0);
        idle(3);
        chk("R4 zero write no effect", 32'(irq_cnt[0] - c0), 0);
        wr(1, 32'h1);
        idle(3);
        chk("R4 release fires", 32'(irq_cnt[0] - c0), 1);
        expect_fetch("R10 vector", 0, 1'b1, 5);
        wr(16, 32'h0);
        wr(1, 32'hFFF);
        idle(2);

        // R6 R9 R3: table of patterns
        for (int r = 0; r < 8; r++) begin
            int g;
            logic [7:0] en, pm;
            g  = int'(ROWS[r][31:24]);
            en = ROWS[r][23:16];
            pm = ROWS[r][15:8];
            c0 = irq_cnt[g];
            wr(16 + g, 32'(en));
            pulse(NS'(pm) << (g * GS));
            idle(3);
            chk("R3 row irq", 32'(irq_cnt[g] - c0), 32'(ROWS[r][7]));
            expect_fetch("R6 R9 row fetch", g, ROWS[r][7], int'(ROWS[r][6:0]));
            wr(16 + g, 32'hFF);
            repeat (GS) fetch(g);
            wr(16 + g, 32'h0);
            wr(1, 32'hFFF);
            idle(2);
        end

        // R9: disabled source held until enabled
        c0 = irq_cnt[4];
        pulse(NS'(1) << 38);
        idle(3);
        chk("R9 disabled no irq", 32'(irq_cnt[4] - c0), 0);
        expect_fetch("R9 disabled not selected", 4, 1'b0, 0);
        wr(20, 32'h40);
        idle(3);
        chk("R9 irq after enable", 32'(irq_cnt[4] - c0), 1);
        expect_fetch("R9 held flag served", 4, 1'b1, 38);
        wr(20, 32'h0);
        wr(1, 32'hFFF);

        // R8: event collides with its own clear
        wr(24, 32'hFF);
        pulse(NS'(1) << 66);
        fetch_req = 1'b1;
        fetch_grp = 4'd8;
        src_pulse = NS'(1) << 66;
        @(negedge clk);
        fetch_req = 1'b0;
        src_pulse = '0;
        chk("R8 first serve", 32'(fetch_src), 66);
        expect_fetch("R8 flag kept", 8, 1'b1, 66);
        expect_fetch("R8 then empty", 8, 1'b0, 0);
        wr(24, 32'h0);
        wr(1, 32'hFFF);

        // R7: one flag cleared per serve
        wr(25, 32'hFF);
        pulse((NS'(1) << 74) | (NS'(1) << 76));
        expect_fetch("R7 lowest first", 9, 1'b1, 74);
        expect_fetch("R7 other kept", 9, 1'b1, 76);
        expect_fetch("R7 empty", 9, 1'b0, 0);
        wr(25, 32'h0);
        wr(1, 32'hFFF);

        // R11: out-of-range group
        wr(16, 32'hFF);
        pulse(NS'(1));
        expect_fetch("R11 group 12", 12, 1'b0, 0);
        expect_fetch("R11 group 15", 15, 1'b0, 0);
        expect_fetch("R11 flag untouched", 0, 1'b1, 0);
        wr(16, 32'h0);
        wr(1, 32'hFFF);

        // R5: disable again, flags kept
        wr(0, 32'h0);
        wr(26, 32'hFF);
        idle(2);
        c0 = irq_cnt[10];
        pulse(NS'(1) << 85);
        idle(3);
        chk("R5 off no irq", 32'(irq_cnt[10] - c0), 0);
        expect_fetch("R5 off no fetch", 10, 1'b0, 0);
        wr(0, 32'h1);
        idle(3);
        chk("R5 irq after re-enable", 32'(irq_cnt[10] - c0), 1);
        expect_fetch("R5 flag kept", 10, 1'b1, 85);

        summary();
    end
endmodule